// File: doc/BRIEF.md
# Host-Side Interrupt Vector Port

This block sits at the host end of an I/O link. An adapter on the far side sends interrupt packets, each holding a vector and an interrupt level. The block keeps one vector slot for each level. It stores an incoming vector in its slot and then raises the interrupt toward the processors. It does this with a broadcast register write whose index is the port's node ID and whose payload is the level plus a 16-bit processor target mask. The mask comes from a local register that software-side logic can rewrite.

A processor takes the interrupt by reading the vector slot for a level. If the slot is pending, the read returns the vector and frees the slot. If it is empty, the read returns zero, and the processor treats that as a passive release. Each vector from the link that is consumed sends a status-return strobe downstream, which lets the adapter post again at that level.

Errors that the port detects itself are raised at level 17 with a fixed error vector. They queue behind any link vector that already holds level 17. A packet that arrives for a level that is still pending breaks the link's flow control. The port drops that packet and treats it as one of these internal errors. Packet framing and the system bus are reduced to single-cycle strobes.

Top module: `intr_vector_port`

## Requirements
- R1: A packet at a level with no pending vector stores its vector and marks the level pending. On the next cycle the port drives one broadcast write with index equal to `nodeId`, level equal to the packet level, and the current mask.
- R2: The target mask resets to all ones and is replaced by `maskWrData` when `maskWrEn` is high. A broadcast launched in the same cycle as a mask write carries the mask value held before that write.
- R3: A read of a pending level gives, one cycle later, `rdRespValid` high with `rdData` equal to the stored vector, and the level stops being pending.
- R4: A read of a level with nothing pending gives `rdRespValid` high with `rdData` equal to zero and no status return.
- R5: Consuming a vector that came from the link raises `statValid` for one cycle, in the same cycle as the read response, with `statLevel` equal to the level read.
- R6: An `errValid` pulse leads to a broadcast at level 17 and to a pending level-17 vector equal to `ERR_VECTOR`. Consuming this vector raises no status return.
- R7: A queued error loads only in a cycle where level 17 is not pending and no packet arrives. A link vector held at level 17 is therefore served first, and the error vector follows after that vector is read.
- R8: A packet for a level that is already pending is dropped, leaving the stored vector unchanged, and counts as an internal error under R6.
- R9: After reset no level is pending and `bcastValid`, `rdRespValid`, `rdData` and `statValid` are all zero.
- R10: Errors that arrive while an error is already queued merge into one error interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nodeId | input | NODE_W | Node ID of this port; used as the broadcast index |
| pktValid | input | 1 | Interrupt packet strobe from the link |
| pktLevel | input | LEVEL_W | Level of the packet |
| pktVector | input | VEC_W | Vector of the packet |
| errValid | input | 1 | Internally detected error strobe |
| maskWrEn | input | 1 | Mask register write strobe |
| maskWrData | input | MASK_W | New processor target mask |
| rdValid | input | 1 | Processor read of a vector slot |
| rdLevel | input | LEVEL_W | Level read |
| rdRespValid | output | 1 | Read response strobe |
| rdData | output | VEC_W | Vector returned, zero when nothing is pending |
| bcastValid | output | 1 | Broadcast interrupt register write strobe |
| bcastIndex | output | NODE_W | Broadcast register index |
| bcastLevel | output | LEVEL_W | Interrupt level written |
| bcastMask | output | MASK_W | Processor target mask written |
| statValid | output | 1 | Status return to the adapter |
| statLevel | output | LEVEL_W | Level whose vector was consumed |

## Verification
Suppose a pending bit is wrong. The next read of that level would return zero instead of a vector, or a vector instead of zero. The status return would then be missing or extra, and both show up one cycle after the read. If a packet were wrongly dropped or wrongly accepted, the broadcast would be missing or extra on the cycle after the packet. A lost or duplicated error queue entry changes how many level-17 broadcasts appear. A wrong source tag on slot 17 shows up as a status return at the read response. The bench checks every output against a behavioural model on every clock, so each of these errors appears within one or two cycles of its cause.

// File: rtl/ivp_pkg.sv
package ivp_pkg;

  // Strobes from control to datapath, one cycle's decisions
  typedef struct packed {
    logic loadLink;   // store packet vector at pktLevel
    logic loadErr;    // store error vector at the error level
    logic consume;    // clear pending bit at rdLevel
    logic readHit;    // read targets a pending level
  } ivpStrobes_t;

endpackage

// File: rtl/ivp_control.sv
module ivp_control
  import ivp_pkg::*;
#(
  parameter int NUM_LEVELS = 32,
  parameter int ERR_LEVEL  = 17,
  localparam int LEVEL_W   = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pktValid,
  input  logic [LEVEL_W-1:0]    pktLevel,
  input  logic                  errValid,
  input  logic                  rdValid,
  input  logic [LEVEL_W-1:0]    rdLevel,
  input  logic [NUM_LEVELS-1:0] validVec,
  input  logic [NUM_LEVELS-1:0] errSrcVec,
  output ivpStrobes_t           str,
  output logic                  bcastValid,
  output logic                  rdRespValid,
  output logic                  statValid,
  output logic [LEVEL_W-1:0]    statLevel
);

  logic errPend;
  logic dupPkt;
  logic errSlotBusy;

  assign dupPkt      = pktValid && validVec[pktLevel];
  assign errSlotBusy = validVec[ERR_LEVEL];

  always_comb begin
    str          = '0;
    str.loadLink = pktValid && !dupPkt;
    str.loadErr  = errPend && !pktValid && !errSlotBusy;
    str.readHit  = rdValid && validVec[rdLevel];
    str.consume  = str.readHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errPend     <= 1'b0;
      bcastValid  <= 1'b0;
      rdRespValid <= 1'b0;
      statValid   <= 1'b0;
      statLevel   <= '0;
    end else begin
      errPend     <= (errPend && !str.loadErr) || errValid || dupPkt;
      bcastValid  <= str.loadLink || str.loadErr;
      rdRespValid <= rdValid;
      statValid   <= str.readHit && !errSrcVec[rdLevel];
      if (str.readHit) statLevel <= rdLevel;
    end
  end

  // R5
  stat_with_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    statValid |-> rdRespValid);

  // R7
  one_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({str.loadLink, str.loadErr}));

  // R8
  dup_raises_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    dupPkt |=> errPend);

  // R4
  empty_no_stat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !validVec[rdLevel]) |=> !statValid);

endmodule

// File: rtl/ivp_datapath.sv
module ivp_datapath
  import ivp_pkg::*;
#(
  parameter int              NUM_LEVELS = 32,
  parameter int              ERR_LEVEL  = 17,
  parameter int              VEC_W      = 16,
  parameter int              MASK_W     = 16,
  parameter int              NODE_W     = 4,
  parameter logic [VEC_W-1:0] ERR_VECTOR = 16'h0E17,
  localparam int             LEVEL_W    = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ivpStrobes_t           str,
  input  logic [NODE_W-1:0]     nodeId,
  input  logic [LEVEL_W-1:0]    pktLevel,
  input  logic [VEC_W-1:0]      pktVector,
  input  logic                  maskWrEn,
  input  logic [MASK_W-1:0]     maskWrData,
  input  logic [LEVEL_W-1:0]    rdLevel,
  output logic [NUM_LEVELS-1:0] validVec,
  output logic [NUM_LEVELS-1:0] errSrcVec,
  output logic [VEC_W-1:0]      rdData,
  output logic [NODE_W-1:0]     bcastIndex,
  output logic [LEVEL_W-1:0]    bcastLevel,
  output logic [MASK_W-1:0]     bcastMask
);

  logic [VEC_W-1:0]  slotVecArr [NUM_LEVELS];
  logic [MASK_W-1:0] maskReg;

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : gLevel
    logic [VEC_W-1:0] slotVec;
    logic             slotValid;
    logic             slotErrSrc;
    logic             linkHere;
    logic             errHere;
    logic             clrHere;

    assign linkHere = str.loadLink && (pktLevel == LEVEL_W'(g));
    assign errHere  = str.loadErr && (g == ERR_LEVEL);
    assign clrHere  = str.consume && (rdLevel == LEVEL_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotVec    <= '0;
        slotValid  <= 1'b0;
        slotErrSrc <= 1'b0;
      end else if (linkHere) begin
        slotVec    <= pktVector;
        slotValid  <= 1'b1;
        slotErrSrc <= 1'b0;
      end else if (errHere) begin
        slotVec    <= ERR_VECTOR;
        slotValid  <= 1'b1;
        slotErrSrc <= 1'b1;
      end else if (clrHere) begin
        slotValid  <= 1'b0;
      end
    end

    assign slotVecArr[g] = slotVec;
    assign validVec[g]   = slotValid;
    assign errSrcVec[g]  = slotErrSrc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg    <= '1;
      rdData     <= '0;
      bcastIndex <= '0;
      bcastLevel <= '0;
      bcastMask  <= '0;
    end else begin
      if (maskWrEn) maskReg <= maskWrData;
      rdData <= str.readHit ? slotVecArr[rdLevel] : '0;
      if (str.loadLink || str.loadErr) begin
        bcastIndex <= nodeId;
        bcastLevel <= str.loadErr ? LEVEL_W'(ERR_LEVEL) : pktLevel;
        bcastMask  <= maskReg;
      end
    end
  end

  // R1
  load_sets_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.loadLink |=> validVec[$past(pktLevel)]);

  // R3
  consume_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.consume |=> !validVec[$past(rdLevel)]);

  // R6
  err_slot_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.loadErr |=> (validVec[ERR_LEVEL] && errSrcVec[ERR_LEVEL]));

endmodule

// File: rtl/intr_vector_port.sv
module intr_vector_port
  import ivp_pkg::*;
#(
  parameter int              NUM_LEVELS = 32,
  parameter int              ERR_LEVEL  = 17,
  parameter int              VEC_W      = 16,
  parameter int              MASK_W     = 16,
  parameter int              NODE_W     = 4,
  parameter logic [VEC_W-1:0] ERR_VECTOR = 16'h0E17,
  localparam int             LEVEL_W    = $clog2(NUM_LEVELS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NODE_W-1:0]  nodeId,
  input  logic               pktValid,
  input  logic [LEVEL_W-1:0] pktLevel,
  input  logic [VEC_W-1:0]   pktVector,
  input  logic               errValid,
  input  logic               maskWrEn,
  input  logic [MASK_W-1:0]  maskWrData,
  input  logic               rdValid,
  input  logic [LEVEL_W-1:0] rdLevel,
  output logic               rdRespValid,
  output logic [VEC_W-1:0]   rdData,
  output logic               bcastValid,
  output logic [NODE_W-1:0]  bcastIndex,
  output logic [LEVEL_W-1:0] bcastLevel,
  output logic [MASK_W-1:0]  bcastMask,
  output logic               statValid,
  output logic [LEVEL_W-1:0] statLevel
);

  ivpStrobes_t           str;
  logic [NUM_LEVELS-1:0] validVec;
  logic [NUM_LEVELS-1:0] errSrcVec;

  ivp_control #(
    .NUM_LEVELS(NUM_LEVELS),
    .ERR_LEVEL (ERR_LEVEL)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pktValid   (pktValid),
    .pktLevel   (pktLevel),
    .errValid   (errValid),
    .rdValid    (rdValid),
    .rdLevel    (rdLevel),
    .validVec   (validVec),
    .errSrcVec  (errSrcVec),
    .str        (str),
    .bcastValid (bcastValid),
    .rdRespValid(rdRespValid),
    .statValid  (statValid),
    .statLevel  (statLevel)
  );

  ivp_datapath #(
    .NUM_LEVELS(NUM_LEVELS),
    .ERR_LEVEL (ERR_LEVEL),
    .VEC_W     (VEC_W),
    .MASK_W    (MASK_W),
    .NODE_W    (NODE_W),
    .ERR_VECTOR(ERR_VECTOR)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .str       (str),
    .nodeId    (nodeId),
    .pktLevel  (pktLevel),
    .pktVector (pktVector),
    .maskWrEn  (maskWrEn),
    .maskWrData(maskWrData),
    .rdLevel   (rdLevel),
    .validVec  (validVec),
    .errSrcVec (errSrcVec),
    .rdData    (rdData),
    .bcastIndex(bcastIndex),
    .bcastLevel(bcastLevel),
    .bcastMask (bcastMask)
  );

endmodule

// File: tb/test_intr_vector_port.sv
module test_intr_vector_port;

  localparam int ERRV = 16'h0E17;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  nodeId = 4'd8;
  logic        pktValid = 1'b0;
  logic [4:0]  pktLevel = '0;
  logic [15:0] pktVector = '0;
  logic        errValid = 1'b0;
  logic        maskWrEn = 1'b0;
  logic [15:0] maskWrData = '0;
  logic        rdValid = 1'b0;
  logic [4:0]  rdLevel = '0;
  logic        rdRespValid, bcastValid, statValid;
  logic [15:0] rdData, bcastMask;
  logic [3:0]  bcastIndex;
  logic [4:0]  bcastLevel, statLevel;

  intr_vector_port i_intr_vector_port (
    .clk(clk), .rstN(rstN), .nodeId(nodeId),
    .pktValid(pktValid), .pktLevel(pktLevel), .pktVector(pktVector),
    .errValid(errValid), .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .rdValid(rdValid), .rdLevel(rdLevel),
    .rdRespValid(rdRespValid), .rdData(rdData),
    .bcastValid(bcastValid), .bcastIndex(bcastIndex), .bcastLevel(bcastLevel),
    .bcastMask(bcastMask), .statValid(statValid), .statLevel(statLevel)
  );

  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int bcast17 = 0;

  // behavioural reference state
  int mVec[32];
  bit mPend[32];
  bit mErr[32];
  bit mQ;
  int mMask;
  bit eRV, eBV, eSV;
  int eRD, eIdx, eLvl, eMsk, eSL;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 32; i++) begin
      mVec[i] = 0; mPend[i] = 0; mErr[i] = 0;
    end
    mQ = 0; mMask = 16'hFFFF;
    eRV = 0; eBV = 0; eSV = 0; eRD = 0;
  endtask

  task automatic compareAll();
    check(rdRespValid == eRV && int'(rdData) == eRD, (eRD == 0) ? "R4" : "R3",
          {rdRespValid, rdData}, {eRV, eRD[15:0]});
    check(bcastValid == eBV, (eBV && eLvl == 17) ? "R6" : "R1", bcastValid, eBV);
    if (eBV && bcastValid) begin
      check(int'(bcastIndex) == eIdx && int'(bcastLevel) == eLvl,
            "R1", {bcastIndex, bcastLevel}, {eIdx[3:0], eLvl[4:0]});
      check(int'(bcastMask) == eMsk, "R2", bcastMask, eMsk);
      if (bcastLevel == 17) bcast17++;
    end
    check(statValid == eSV, "R5", statValid, eSV);
    if (eSV && statValid) check(int'(statLevel) == eSL, "R5", statLevel, eSL);
  endtask

  task automatic cyc(input bit pv, input int pl, input int pvec, input bit rv,
                     input int rl, input bit ev, input bit mw, input int md);
    bit dup, ll, le, hit;
    @(negedge clk);
    pktValid = pv; pktLevel = pl[4:0]; pktVector = pvec[15:0];
    rdValid = rv; rdLevel = rl[4:0]; errValid = ev;
    maskWrEn = mw; maskWrData = md[15:0];
    dup = pv && mPend[pl];
    ll  = pv && !dup;
    le  = mQ && !pv && !mPend[17];
    hit = rv && mPend[rl];
    eBV = ll || le;
    if (eBV) begin
      eIdx = int'(nodeId); eLvl = le ? 17 : pl; eMsk = mMask;
    end
    eRV = rv;
    eRD = hit ? mVec[rl] : 0;
    eSV = hit && !mErr[rl];
    if (hit) begin eSL = rl; mPend[rl] = 0; end
    if (ll) begin mVec[pl] = pvec & 16'hFFFF; mPend[pl] = 1; mErr[pl] = 0; end
    if (le) begin mVec[17] = ERRV; mPend[17] = 1; mErr[17] = 1; end
    mQ = (mQ && !le) || ev || dup;
    if (mw) mMask = md & 16'hFFFF;
    @(posedge clk);
    #1;
    compareAll();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int b0;
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    check(!rdRespValid && !bcastValid && !statValid && rdData == 0, "R9",
          {rdRespValid, bcastValid, statValid}, 0);
    @(negedge clk); rstN = 1'b1;
    idle(1);

    // R1, R2: packet with reset mask of all ones, node 8 -> index 8
    cyc(1, 3, 16'h1234, 0, 0, 0, 0, 0);
    check(bcastMask == 16'hFFFF && bcastIndex == 4'd8, "R2", bcastMask, 16'hFFFF);
    // R2: mask write in same cycle as a packet uses old mask
    cyc(1, 5, 16'h5555, 0, 0, 0, 1, 16'h00F0);
    check(bcastMask == 16'hFFFF, "R2", bcastMask, 16'hFFFF);
    nodeId = 4'd7;
    cyc(1, 6, 16'h6666, 0, 0, 0, 0, 0);
    check(bcastMask == 16'h00F0 && bcastIndex == 4'd7, "R2", bcastMask, 16'h00F0);
    // R3, R5: read a pending vector
    cyc(0, 0, 0, 1, 3, 0, 0, 0);
    check(rdData == 16'h1234 && statValid && statLevel == 5'd3, "R3", rdData, 16'h1234);
    // R4: second read of same level returns zero, no status
    cyc(0, 0, 0, 1, 3, 0, 0, 0);
    check(rdRespValid && rdData == 0 && !statValid, "R4", rdData, 0);
    // R8: duplicate at pending level 5 dropped, raises error at 17
    b0 = bcast17;
    cyc(1, 5, 16'hBEEF, 0, 0, 0, 0, 0);
    check(!bcastValid, "R8", bcastValid, 0);
    idle(2);
    check(bcast17 == b0 + 1, "R8", bcast17 - b0, 1);
    cyc(0, 0, 0, 1, 5, 0, 0, 0);
    check(rdData == 16'h5555, "R8", rdData, 16'h5555);
    // R6: error vector read gives no status return
    cyc(0, 0, 0, 1, 17, 0, 0, 0);
    check(rdData == 16'(ERRV) && !statValid, "R6", rdData, ERRV);
    // R7, R10: link vector at 17 first, then merged errors
    b0 = bcast17;
    cyc(1, 17, 16'hA17A, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    idle(3);
    check(bcast17 == b0 + 1, "R7", bcast17 - b0, 1);
    cyc(0, 0, 0, 1, 17, 0, 0, 0);
    check(rdData == 16'hA17A && statValid, "R7", rdData, 16'hA17A);
    idle(3);
    check(bcast17 == b0 + 2, "R10", bcast17 - b0, 2);
    cyc(0, 0, 0, 1, 17, 0, 0, 0);
    check(rdData == 16'(ERRV), "R7", rdData, ERRV);
    cyc(0, 0, 0, 1, 17, 0, 0, 0);
    check(rdData == 0, "R10", rdData, 0);

    // mixed traffic, compared every clock against the model
    for (int i = 0; i < 3000; i++) begin
      int lv, rl;
      lv = ($urandom % 4 == 0) ? 17 : int'($urandom % 32);
      rl = ($urandom % 3 == 0) ? 17 : int'($urandom % 32);
      if (i % 500 == 0) nodeId = 4'($urandom);
      cyc($urandom % 3 == 0, lv, int'($urandom % 65536), $urandom % 2 == 0, rl,
          $urandom % 16 == 0, $urandom % 20 == 0, int'($urandom % 65536));
    end
    idle(4);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule